// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a 32-bit processor core that completes one instruction per clock cycle. It supports six instructions: register add without overflow trap, word load, word store, branch on equal, jump through a register and shift left by a constant. A main control decoder turns the opcode and function fields into datapath selects. These selects pick the write-back destination, the second ALU operand, the write-back source, the register write, the memory read and write, and the branch. Two further selects are added for the extended instructions. One puts a register value in front of the program counter for the register jump. The other routes the shift-amount field into the first ALU operand for the shift.

The program counter, a 32-entry register file, an ALU with a shifter, and small instruction and data memories all sit inside the core. A load port lets a test environment fill either memory while the core is idle. A `run` input acts as the core's clock enable. The debug outputs show the current program counter and the register write that will commit at the next rising edge.

Top module: `mini_core`

## Requirements
- R1: An R-format word (opcode bits 31:26 = 0x00) with function field (bits 5:0) = 0x21 writes rs+rt, modulo 2^32, into rd. The register fields are rs = bits 25:21, rt = bits 20:16 and rd = bits 15:11.
- R2: Opcode 0x23 loads the data-memory word at address rs + sign-extended bits 15:0 into rt. The word index is taken from address bits above bit 1.
- R3: Opcode 0x2B stores rt at address rs + sign-extended bits 15:0. It makes no register write.
- R4: An R-format word with function field 0x00 writes rt shifted left by the amount in bits 10:6 into rd.
- R5: Opcode 0x04 compares rs and rt. If they are equal, the next PC is PC+4 plus the sign-extended offset times 4. Otherwise the next PC is PC+4. The instruction makes no register write.
- R6: An R-format word with function field 0x08 sets the next PC to the value of rs and makes no register write.
- R7: Register 0 always reads as zero, and any write that targets it is dropped.
- R8: An unknown opcode or R-format function field writes nothing and does not branch. The PC still advances by 4.
- R9: While `run` is low, the PC holds and no register or memory write from the core takes place. The load port then writes the memory chosen by `load_dmem` (1 = data, 0 = instruction) at word index `load_addr`.
- R10: An asynchronous low on `rst_n` clears the PC and all registers at once. Instructions resume on the second rising edge after `rst_n` goes high.
- R11: `dbg_pc` shows the address of the current instruction. `dbg_wr_en`, `dbg_wr_addr` and `dbg_wr_data` show, in the same cycle, the register write that commits at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Execute enable; low holds the core idle |
| load_en | input | 1 | Load port write strobe, honoured only while idle |
| load_dmem | input | 1 | Load target: 1 data memory, 0 instruction memory |
| load_addr | input | MEM_AW | Word index written by the load port |
| load_data | input | XLEN | Word written by the load port |
| dbg_pc | output | XLEN | Address of the instruction now executing |
| dbg_wr_en | output | 1 | A register write commits at the next edge |
| dbg_wr_addr | output | 5 | Destination register of that write |
| dbg_wr_data | output | XLEN | Value of that write |

## Verification
Every result of the instruction now executing is combinational and appears on the debug write outputs within the same cycle. A new `dbg_pc` becomes visible one rising edge later. After reset is released, the first instruction's write shows up only after the second rising edge. The bench drives inputs on the falling edge and samples one time unit later. A program-counter check therefore refers to the instruction stepped across the preceding rising edge, and a write check refers to the instruction being shown now. The reset test checks the idle state after the first edge and the first write after the second edge.

// File: rtl/mc_pkg.sv
package mc_pkg;

  localparam logic [5:0] OPC_RFMT  = 6'h00;
  localparam logic [5:0] OPC_LOAD  = 6'h23;
  localparam logic [5:0] OPC_STORE = 6'h2B;
  localparam logic [5:0] OPC_BREQ  = 6'h04;

  localparam logic [5:0] FN_ADD    = 6'h21;
  localparam logic [5:0] FN_SHL    = 6'h00;
  localparam logic [5:0] FN_JREG   = 6'h08;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_SHL = 2'd2
  } alu_op_e;

  typedef struct packed {
    logic    dst_is_rd;
    logic    b_is_imm;
    logic    wb_from_mem;
    logic    reg_write;
    logic    mem_read;
    logic    mem_write;
    logic    branch;
    logic    jump_reg;
    logic    a_is_shamt;
    alu_op_e alu_op;
    logic    illegal;
  } ctl_t;

endpackage

// File: rtl/mc_decoder.sv
module mc_decoder
  import mc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctl_t       ctl
);

  always_comb begin
    ctl        = '0;
    ctl.alu_op = ALU_ADD;
    unique case (opcode)
      OPC_RFMT: begin
        unique case (funct)
          FN_ADD: begin
            ctl.dst_is_rd = 1'b1;
            ctl.reg_write = 1'b1;
          end
          FN_SHL: begin
            ctl.dst_is_rd  = 1'b1;
            ctl.reg_write  = 1'b1;
            ctl.a_is_shamt = 1'b1;
            ctl.alu_op     = ALU_SHL;
          end
          FN_JREG: begin
            ctl.jump_reg = 1'b1;
          end
          default: begin
            ctl.illegal = 1'b1;
          end
        endcase
      end
      OPC_LOAD: begin
        ctl.b_is_imm    = 1'b1;
        ctl.wb_from_mem = 1'b1;
        ctl.reg_write   = 1'b1;
        ctl.mem_read    = 1'b1;
      end
      OPC_STORE: begin
        ctl.b_is_imm  = 1'b1;
        ctl.mem_write = 1'b1;
      end
      OPC_BREQ: begin
        ctl.branch = 1'b1;
        ctl.alu_op = ALU_SUB;
      end
      default: begin
        ctl.illegal = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/mc_alu.sv
module mc_alu
  import mc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  input  alu_op_e         op,
  output logic [XLEN-1:0] res,
  output logic            zero
);

  localparam int SHW = $clog2(XLEN);

  logic [XLEN-1:0] diff;
  logic [XLEN-1:0] unused_hi;

  assign diff      = opa - opb;
  assign zero      = (diff == '0);
  assign unused_hi = opa;

  always_comb begin
    unique case (op)
      ALU_SUB: res = diff;
      ALU_SHL: res = opb << opa[SHW-1:0];
      default: res = opa + opb;
    endcase
  end

endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int XLEN  = 32,
  parameter int NREGS = 32,
  localparam int RAW  = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [RAW-1:0]  waddr,
  input  logic [XLEN-1:0] wdata,
  input  logic [RAW-1:0]  raddr_a,
  input  logic [RAW-1:0]  raddr_b,
  output logic [XLEN-1:0] rdata_a,
  output logic [XLEN-1:0] rdata_b
);

  logic [XLEN-1:0] regs_q [NREGS];
  logic            wr_ok;

  assign wr_ok = we && (waddr != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) begin
        regs_q[i] <= '0;
      end
    end else if (wr_ok) begin
      regs_q[waddr] <= wdata;
    end
  end

  assign rdata_a = (raddr_a == '0) ? '0 : regs_q[raddr_a];
  assign rdata_b = (raddr_b == '0) ? '0 : regs_q[raddr_b];

endmodule

// File: rtl/mc_mem.sv
module mc_mem #(
  parameter int WIDTH = 32,
  parameter int AW    = 6,
  localparam int DEPTH = 1 << AW
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      cells[waddr] <= wdata;
    end
  end

  assign rdata = cells[raddr];

endmodule

// File: rtl/mc_rst_sync.sv
module mc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      assign chain_d = 1'b1;
    end else begin : g_multi
      assign chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/mini_core.sv
module mini_core
  import mc_pkg::*;
#(
  parameter int XLEN        = 32,
  parameter int MEM_AW      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              load_en,
  input  logic              load_dmem,
  input  logic [MEM_AW-1:0] load_addr,
  input  logic [XLEN-1:0]   load_data,
  output logic [XLEN-1:0]   dbg_pc,
  output logic              dbg_wr_en,
  output logic [4:0]        dbg_wr_addr,
  output logic [XLEN-1:0]   dbg_wr_data
);

  localparam int NREGS = 32;
  localparam int RAW   = $clog2(NREGS);
  localparam int SAW   = 5;

  logic            rst_core_n;
  logic            core_en;
  logic [XLEN-1:0] pc_q;
  logic [XLEN-1:0] pc_d;
  logic [XLEN-1:0] pc_plus4;
  logic [XLEN-1:0] br_target;
  logic [31:0]     instr;
  ctl_t            ctl;

  logic [5:0]      f_opc;
  logic [RAW-1:0]  f_rs;
  logic [RAW-1:0]  f_rt;
  logic [RAW-1:0]  f_rd;
  logic [SAW-1:0]  f_sh;
  logic [5:0]      f_fn;
  logic [XLEN-1:0] imm_sx;

  logic [XLEN-1:0] rs_val;
  logic [XLEN-1:0] rt_val;
  logic [XLEN-1:0] alu_a;
  logic [XLEN-1:0] alu_b;
  logic [XLEN-1:0] alu_y;
  logic            alu_zero;
  logic [RAW-1:0]  wb_addr;
  logic [XLEN-1:0] wb_data;
  logic            rf_we;

  logic              imem_we;
  logic              dmem_we;
  logic [MEM_AW-1:0] dmem_waddr;
  logic [XLEN-1:0]   dmem_wdata;
  logic [XLEN-1:0]   dmem_rdata;
  logic [MEM_AW-1:0] daddr_idx;
  logic              unused_bits;

  mc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  assign core_en = run & rst_core_n;

  // Instruction fetch
  mc_mem #(.WIDTH(32), .AW(MEM_AW)) u_imem (
    .clk   (clk),
    .we    (imem_we),
    .waddr (load_addr),
    .wdata (load_data[31:0]),
    .raddr (pc_q[MEM_AW+1:2]),
    .rdata (instr)
  );

  assign imem_we = load_en & ~load_dmem & ~core_en;

  // Field split
  assign f_opc  = instr[31:26];
  assign f_rs   = instr[25:21];
  assign f_rt   = instr[20:16];
  assign f_rd   = instr[15:11];
  assign f_sh   = instr[10:6];
  assign f_fn   = instr[5:0];
  assign imm_sx = {{(XLEN-16){instr[15]}}, instr[15:0]};

  mc_decoder u_dec (
    .opcode (f_opc),
    .funct  (f_fn),
    .ctl    (ctl)
  );

  mc_regfile #(.XLEN(XLEN), .NREGS(NREGS)) u_rf (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .we      (rf_we),
    .waddr   (wb_addr),
    .wdata   (wb_data),
    .raddr_a (f_rs),
    .raddr_b (f_rt),
    .rdata_a (rs_val),
    .rdata_b (rt_val)
  );

  // Operand selection
  assign alu_a = ctl.a_is_shamt ? {{(XLEN-SAW){1'b0}}, f_sh} : rs_val;
  assign alu_b = ctl.b_is_imm   ? imm_sx : rt_val;

  mc_alu #(.XLEN(XLEN)) u_alu (
    .opa  (alu_a),
    .opb  (alu_b),
    .op   (ctl.alu_op),
    .res  (alu_y),
    .zero (alu_zero)
  );

  // Data memory: core port while running, load port while idle
  assign daddr_idx  = alu_y[MEM_AW+1:2];
  assign dmem_we    = core_en ? ctl.mem_write : (load_en & load_dmem);
  assign dmem_waddr = core_en ? daddr_idx : load_addr;
  assign dmem_wdata = core_en ? rt_val    : load_data;

  mc_mem #(.WIDTH(XLEN), .AW(MEM_AW)) u_dmem (
    .clk   (clk),
    .we    (dmem_we),
    .waddr (dmem_waddr),
    .wdata (dmem_wdata),
    .raddr (daddr_idx),
    .rdata (dmem_rdata)
  );

  // Write-back
  assign wb_addr = ctl.dst_is_rd   ? f_rd       : f_rt;
  assign wb_data = ctl.wb_from_mem ? dmem_rdata : alu_y;
  assign rf_we   = core_en & ctl.reg_write;

  // Next PC: register jump first, then taken branch, then sequential
  assign pc_plus4  = pc_q + XLEN'(4);
  assign br_target = pc_plus4 + {imm_sx[XLEN-3:0], 2'b00};

  always_comb begin
    if (ctl.jump_reg) begin
      pc_d = rs_val;
    end else if (ctl.branch && alu_zero) begin
      pc_d = br_target;
    end else begin
      pc_d = pc_plus4;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      pc_q <= '0;
    end else if (core_en) begin
      pc_q <= pc_d;
    end
  end

  assign dbg_pc      = pc_q;
  assign dbg_wr_en   = rf_we & (wb_addr != '0);
  assign dbg_wr_addr = wb_addr;
  assign dbg_wr_data = wb_data;

  assign unused_bits = ^{alu_y[1:0], alu_y[XLEN-1:MEM_AW+2], ctl.mem_read, ctl.illegal};

endmodule

// File: rtl/mini_core_chk.sv
module mini_core_chk
  import mc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            run,
  input logic            core_en,
  input ctl_t            ctl,
  input logic [XLEN-1:0] pc_q,
  input logic [XLEN-1:0] rs_val,
  input logic            dbg_wr_en
);

  AST_IDLE_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !core_en |=> $stable(pc_q)); // R9

  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !dbg_wr_en); // R9

  AST_SEQ_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    core_en && !ctl.jump_reg && !ctl.branch |=> pc_q == $past(pc_q) + XLEN'(4)); // R8

  AST_JR_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    core_en && ctl.jump_reg |=> pc_q == $past(rs_val)); // R6

  AST_STORE_NO_REGWR: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.mem_write |-> !ctl.reg_write && !dbg_wr_en); // R3

  AST_ILLEGAL_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    core_en && ctl.illegal |-> !dbg_wr_en && !ctl.mem_write && !ctl.branch); // R8

  AST_CTL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctl.mem_read, ctl.mem_write, ctl.branch, ctl.jump_reg})); // R2

endmodule

bind mini_core mini_core_chk #(.XLEN(XLEN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .run       (run),
  .core_en   (core_en),
  .ctl       (ctl),
  .pc_q      (pc_q),
  .rs_val    (rs_val),
  .dbg_wr_en (dbg_wr_en)
);

// File: tb/mini_core_tb.sv
module mini_core_tb;

  localparam int XLEN   = 32;
  localparam int MEM_AW = 6;

  logic              clk;
  logic              rst_n;
  logic              run;
  logic              load_en;
  logic              load_dmem;
  logic [MEM_AW-1:0] load_addr;
  logic [XLEN-1:0]   load_data;
  logic [XLEN-1:0]   dbg_pc;
  logic              dbg_wr_en;
  logic [4:0]        dbg_wr_addr;
  logic [XLEN-1:0]   dbg_wr_data;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  mini_core #(.XLEN(XLEN), .MEM_AW(MEM_AW)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (run),
    .load_en     (load_en),
    .load_dmem   (load_dmem),
    .load_addr   (load_addr),
    .load_data   (load_data),
    .dbg_pc      (dbg_pc),
    .dbg_wr_en   (dbg_wr_en),
    .dbg_wr_addr (dbg_wr_addr),
    .dbg_wr_data (dbg_wr_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, int sh, logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'(sh), fn};
  endfunction

  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load_word(bit to_dmem, int idx, logic [31:0] val);
    @(negedge clk);
    load_en   = 1'b1;
    load_dmem = to_dmem;
    load_addr = MEM_AW'(idx);
    load_data = val;
    @(negedge clk);
    load_en   = 1'b0;
  endtask

  task automatic clear_imem();
    for (int i = 0; i < (1 << MEM_AW); i++) load_word(1'b0, i, 32'h0);
  endtask

  task automatic start_core();
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    run = 1'b1;
  endtask

  // Check the current instruction, then cross one rising edge
  task automatic step(string req, logic [31:0] pc, bit we, int wa, logic [31:0] wd);
    #1;
    chk({req, " pc"}, dbg_pc, pc);
    chk({req, " wr_en"}, 32'(dbg_wr_en), 32'(we));
    if (we) begin
      chk({req, " wr_addr"}, 32'(dbg_wr_addr), 32'(wa));
      chk({req, " wr_data"}, dbg_wr_data, wd);
    end
    @(negedge clk);
  endtask

  task automatic test_arith_mem();
    rst_n = 1'b0;
    run   = 1'b0;
    clear_imem();
    load_word(1'b1, 0, 32'd5);
    load_word(1'b1, 1, 32'hFFFF_FFF0);
    load_word(1'b1, 2, 32'h1234_5678);
    load_word(1'b0, 0,  enc_i(6'h23, 0, 1, 16'd0));
    load_word(1'b0, 1,  enc_i(6'h23, 0, 2, 16'd4));
    load_word(1'b0, 2,  enc_r(1, 2, 3, 0, 6'h21));
    load_word(1'b0, 3,  enc_r(0, 1, 4, 3, 6'h00));
    load_word(1'b0, 4,  enc_i(6'h2B, 0, 3, 16'd12));
    load_word(1'b0, 5,  enc_i(6'h23, 0, 5, 16'd12));
    load_word(1'b0, 6,  enc_r(1, 1, 0, 0, 6'h21));
    load_word(1'b0, 7,  enc_r(0, 1, 6, 0, 6'h21));
    load_word(1'b0, 8,  enc_i(6'h23, 4, 7, 16'hFFE0));
    load_word(1'b0, 9,  enc_r(0, 1, 9, 31, 6'h00));
    load_word(1'b0, 10, {6'h3F, 26'h0});
    load_word(1'b0, 11, enc_r(1, 1, 11, 0, 6'h22));
    load_word(1'b0, 12, enc_r(9, 9, 10, 0, 6'h21));
    start_core();
    step("R2 lw base",        32'd0,  1, 1, 32'd5);
    step("R2 lw positive",    32'd4,  1, 2, 32'hFFFF_FFF0);
    step("R1 addu",           32'd8,  1, 3, 32'hFFFF_FFF5);
    step("R4 sll by 3",       32'd12, 1, 4, 32'd40);
    step("R3 sw no regwr",    32'd16, 0, 0, 32'd0);
    step("R3 sw readback",    32'd20, 1, 5, 32'hFFFF_FFF5);
    step("R7 write r0",       32'd24, 0, 0, 32'd0);
    step("R7 read r0",        32'd28, 1, 6, 32'd5);
    step("R2 lw neg offset",  32'd32, 1, 7, 32'h1234_5678);
    step("R4 sll by 31",      32'd36, 1, 9, 32'h8000_0000);
    step("R8 bad opcode",     32'd40, 0, 0, 32'd0);
    step("R8 bad funct",      32'd44, 0, 0, 32'd0);
    step("R1 addu wrap",      32'd48, 1, 10, 32'd0);
    run = 1'b0;
  endtask

  task automatic test_flow();
    rst_n = 1'b0;
    run   = 1'b0;
    clear_imem();
    load_word(1'b1, 0, 32'd7);
    load_word(1'b1, 1, 32'd7);
    load_word(1'b1, 2, 32'd9);
    load_word(1'b1, 3, 32'd64);
    load_word(1'b0, 0,  enc_i(6'h23, 0, 1, 16'd0));
    load_word(1'b0, 1,  enc_i(6'h23, 0, 2, 16'd4));
    load_word(1'b0, 2,  enc_i(6'h23, 0, 3, 16'd8));
    load_word(1'b0, 3,  enc_i(6'h04, 1, 3, 16'd5));
    load_word(1'b0, 4,  enc_i(6'h04, 1, 2, 16'd2));
    load_word(1'b0, 5,  enc_r(1, 1, 20, 0, 6'h21));
    load_word(1'b0, 6,  enc_r(1, 1, 21, 0, 6'h21));
    load_word(1'b0, 7,  enc_i(6'h23, 0, 5, 16'd12));
    load_word(1'b0, 8,  enc_r(5, 0, 0, 0, 6'h08));
    load_word(1'b0, 16, enc_i(6'h04, 0, 0, 16'hFFFF));
    start_core();
    step("R2 lw a",           32'd0,  1, 1, 32'd7);
    step("R2 lw b",           32'd4,  1, 2, 32'd7);
    step("R2 lw c",           32'd8,  1, 3, 32'd9);
    step("R5 beq not taken",  32'd12, 0, 0, 32'd0);
    step("R5 beq taken",      32'd16, 0, 0, 32'd0);
    step("R5 branch target",  32'd28, 1, 5, 32'd64);
    step("R6 jr",             32'd32, 0, 0, 32'd0);
    step("R6 jr target",      32'd64, 0, 0, 32'd0);
    step("R5 backward loop",  32'd64, 0, 0, 32'd0);
    run = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    chk("R9 idle pc hold", dbg_pc, 32'd64);
    chk("R9 idle no write", 32'(dbg_wr_en), 32'd0);
  endtask

  task automatic test_reset();
    // Core is idle at PC 64 with live register values
    load_word(1'b0, 0, enc_r(2, 3, 1, 0, 6'h21));
    load_word(1'b0, 1, enc_r(1, 2, 4, 0, 6'h21));
    run = 1'b1;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R10 async pc clear", dbg_pc, 32'd0);
    chk("R10 no write in reset", 32'(dbg_wr_en), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk("R10 held after edge 1", 32'(dbg_wr_en), 32'd0);
    chk("R10 pc after edge 1", dbg_pc, 32'd0);
    @(negedge clk);
    step("R10 regs cleared",  32'd0, 1, 1, 32'd0);
    step("R10 second instr",  32'd4, 1, 4, 32'd0);
    run = 1'b0;
  endtask

  initial begin
    rst_n     = 1'b0;
    run       = 1'b0;
    load_en   = 1'b0;
    load_dmem = 1'b0;
    load_addr = '0;
    load_data = '0;
    repeat (2) @(negedge clk);
    #1;
    chk("R10 reset pc", dbg_pc, 32'd0);
    chk("R11 reset no write", 32'(dbg_wr_en), 32'd0);
    test_arith_mem();
    test_flow();
    test_reset();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule